// File: doc/BRIEF.md
# Verb-Addressed Mailbox Register Pair

This block sits on the codec side of an audio link. It receives decoded commands, each made of a node address, a 12-bit verb code and an 8-bit payload. Commands addressed to the audio function-group node read and write two 32-bit mailbox registers. Each register has one read verb, which returns all 32 bits, and four write verbs. Each write verb replaces one byte lane. A producer on the host side uses the first register to publish an audio format code and a valid flag. A consuming controller on the other side picks up those fields.

The producer signals a new setting by flipping the top bit of the first register. A write that flips that bit in either direction sets a sticky interrupt toward the consumer. The consumer clears it with a one-cycle acknowledge pulse. The block also exports the format field and the valid flag as dedicated outputs, so the consumer does not have to decode the register.

Top module: `svr_mailbox_pair`

## Requirements
- R1: A command is accepted only when `cmd_valid` is high and `cmd_node` equals 0x01. A command with any other node address produces no response and changes neither register nor the interrupt.
- R2: Verb 0xFA6 returns all 32 bits of mailbox 0 on `rsp_data`. Verb 0xFAB returns all 32 bits of mailbox 1.
- R3: Verbs 0xFA7, 0xFA8, 0xFA9 and 0xFAA copy the payload into mailbox 0, bits 7:0, 15:8, 23:16 and 31:24 respectively. The other bytes keep their values.
- R4: Verbs 0xFAC, 0xFAD, 0xFAE and 0xFAF copy the payload into mailbox 1, bits 7:0, 15:8, 23:16 and 31:24 respectively. Writes to mailbox 1 never affect the interrupt.
- R5: Bit 31 of mailbox 0 is the trigger and is written from payload bit 7 of verb 0xFAA. Such a write sets `irq` on the next clock edge when the new bit differs from the stored bit, whether it rises or falls. A write that leaves the bit unchanged does not set `irq`.
- R6: `irq` stays high until a cycle in which `irq_ack` is high. If a trigger change lands in the same cycle as the acknowledge, `irq` stays high.
- R7: Each accepted command produces exactly one `rsp_valid` pulse, one clock after it is presented. Write verbs return 0.
- R8: An accepted verb that is neither a read nor a write verb of either register returns 0 and changes no state.
- R9: After reset both registers read 0 and `irq` is low.
- R10: `fmt_code` shows bits 15:0 of mailbox 0. `fmt_valid` shows bit 30, which is written from payload bit 6 of verb 0xFAA. Both follow a write on the clock that performs it. Bits 29:16 are stored and read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_node | input | 8 | Target node address |
| cmd_verb | input | 12 | Verb code |
| cmd_data | input | 8 | Verb payload |
| irq_ack | input | 1 | Consumer acknowledge pulse |
| rsp_valid | output | 1 | Response strobe, one clock after an accepted command |
| rsp_data | output | 32 | Response word |
| regs_q | output | 64 | Mailbox contents, mailbox 0 in bits 31:0 |
| irq | output | 1 | Sticky trigger-change interrupt |
| fmt_code | output | 16 | Format field of mailbox 0 |
| fmt_valid | output | 1 | Valid flag of mailbox 0 |

## Verification
Two events can hit the interrupt flop in the same cycle: a trigger-flipping write to the top byte of mailbox 0, and the consumer's acknowledge. The bench drives both in a single cycle while the interrupt is already pending and expects it to stay high. It then acknowledges alone and expects it to clear. The same top-byte verb is also sent with the trigger bit unchanged, flipped upward and flipped downward. Each time, the interrupt, the register contents and the scoreboarded response are compared against a model kept in the bench.

// File: rtl/svr_pkg.sv
// Package: shared widths and the decoded-command kind for the mailbox pair.
// Assumes the command fields arrive already deframed from the serial link.
package svr_pkg;

    localparam int NODE_W = 8;
    localparam int VERB_W = 12;
    localparam int PAY_W  = 8;

    typedef enum logic [1:0] {
        VOP_IDLE    = 2'd0,
        VOP_READ    = 2'd1,
        VOP_WRITE   = 2'd2,
        VOP_UNKNOWN = 2'd3
    } verb_op_e;

endpackage

// File: rtl/svr_verb_decode.sv
// Module: svr_verb_decode
// Turns one command into an operation kind, a register index and a byte lane.
// Each register owns a slot of BYTES+1 consecutive verbs starting at
// VERB_BASE + index*(BYTES+1): the first verb reads, the next ones write
// lanes 0 upward. Assumes the verb codes of all slots fit in VERB_W bits.
module svr_verb_decode
    import svr_pkg::*;
#(
    parameter int               NUM_REGS  = 2,
    parameter int               BYTES     = 4,
    parameter logic [NODE_W-1:0] NODE_ID  = 8'h01,
    parameter logic [VERB_W-1:0] VERB_BASE = 12'hFA6,
    localparam int              IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int              LANE_W    = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              cmd_valid,
    input  logic [NODE_W-1:0] cmd_node,
    input  logic [VERB_W-1:0] cmd_verb,
    output logic              accept,
    output verb_op_e          op,
    output logic [IDX_W-1:0]  reg_sel,
    output logic [LANE_W-1:0] lane_sel
);

    localparam int SLOT = BYTES + 1;

    // Node filter: only the function-group node is served.
    assign accept = cmd_valid && (cmd_node == NODE_ID);

    // Verb match: search every register slot for the presented code.
    always_comb begin
        op       = VOP_IDLE;
        reg_sel  = '0;
        lane_sel = '0;
        if (accept) begin
            op = VOP_UNKNOWN;
            for (int r = 0; r < NUM_REGS; r++) begin
                for (int s = 0; s < SLOT; s++) begin
                    if (cmd_verb == VERB_W'(int'(VERB_BASE) + r * SLOT + s)) begin
                        reg_sel = IDX_W'(r);
                        if (s == 0) begin
                            op = VOP_READ;
                        end else begin
                            op       = VOP_WRITE;
                            lane_sel = LANE_W'(s - 1);
                        end
                    end
                end
            end
        end
    end

endmodule

// File: rtl/svr_byte_reg.sv
// Module: svr_byte_reg
// A register of WIDTH bits written one byte lane at a time.
// Assumes WIDTH is a multiple of eight; clears to zero on reset.
module svr_byte_reg #(
    parameter int  WIDTH  = 32,
    localparam int BYTES  = WIDTH / 8,
    localparam int LANE_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LANE_W-1:0] wr_lane,
    input  logic [7:0]        wr_byte,
    output logic [WIDTH-1:0]  q
);

    for (genvar l = 0; l < BYTES; l++) begin : g_lane
        // Lane store: load the payload when this lane is addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[l*8 +: 8] <= 8'h00;
            end else if (wr_en && (wr_lane == LANE_W'(l))) begin
                q[l*8 +: 8] <= wr_byte;
            end
        end
    end

endmodule

// File: rtl/svr_toggle_irq.sv
// Module: svr_toggle_irq
// Sticky interrupt that sets when a write changes the trigger bit in either
// direction and clears on acknowledge. A set in the same cycle beats the clear.
// Assumes the caller qualifies wr_hit with a write to the trigger's lane.
module svr_toggle_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic new_bit,
    input  logic old_bit,
    input  logic ack,
    output logic irq
);

    logic flip;

    // Change detect: the incoming trigger differs from the stored one.
    assign flip = wr_hit && (new_bit != old_bit);

    // Interrupt flop: set has priority over acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (flip) begin
            irq <= 1'b1;
        end else if (ack) begin
            irq <= 1'b0;
        end
    end

endmodule

// File: rtl/svr_mailbox_pair.sv
// Module: svr_mailbox_pair (top)
// Verb-accessed mailbox registers with a trigger-change interrupt on mailbox 0.
// Each accepted command yields one response pulse a clock later; reads
// return the whole register, everything else returns zero.
// Assumes at most one command per cycle and REG_W a multiple of eight.
module svr_mailbox_pair
    import svr_pkg::*;
#(
    parameter int                NUM_REGS  = 2,
    parameter int                REG_W     = 32,
    parameter logic [NODE_W-1:0] NODE_ID   = 8'h01,
    parameter logic [VERB_W-1:0] VERB_BASE = 12'hFA6,
    parameter int                TRIG_BIT  = 31,
    parameter int                VALID_BIT = 30,
    parameter int                FMT_W     = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [NODE_W-1:0]         cmd_node,
    input  logic [VERB_W-1:0]         cmd_verb,
    input  logic [PAY_W-1:0]          cmd_data,
    input  logic                      irq_ack,
    output logic                      rsp_valid,
    output logic [REG_W-1:0]          rsp_data,
    output logic [NUM_REGS*REG_W-1:0] regs_q,
    output logic                      irq,
    output logic [FMT_W-1:0]          fmt_code,
    output logic                      fmt_valid
);

    localparam int BYTES     = REG_W / 8;
    localparam int IDX_W     = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int LANE_W    = (BYTES > 1) ? $clog2(BYTES) : 1;
    localparam int TRIG_LANE = TRIG_BIT / 8;
    localparam int TRIG_POS  = TRIG_BIT % 8;

    logic              accept;
    verb_op_e          op;
    logic [IDX_W-1:0]  reg_sel;
    logic [LANE_W-1:0] lane_sel;
    logic [REG_W-1:0]  rd_word;
    logic              trig_wr;

    svr_verb_decode #(
        .NUM_REGS (NUM_REGS),
        .BYTES    (BYTES),
        .NODE_ID  (NODE_ID),
        .VERB_BASE(VERB_BASE)
    ) u_decode (
        .cmd_valid(cmd_valid),
        .cmd_node (cmd_node),
        .cmd_verb (cmd_verb),
        .accept   (accept),
        .op       (op),
        .reg_sel  (reg_sel),
        .lane_sel (lane_sel)
    );

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
        logic wr_this;

        // Write select: this register is the target of a write verb.
        assign wr_this = (op == VOP_WRITE) && (reg_sel == IDX_W'(r));

        svr_byte_reg #(
            .WIDTH(REG_W)
        ) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_this),
            .wr_lane(lane_sel),
            .wr_byte(cmd_data),
            .q      (regs_q[r*REG_W +: REG_W])
        );
    end

    // Read mux: pick the addressed register's current contents.
    always_comb begin
        rd_word = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (reg_sel == IDX_W'(r)) begin
                rd_word = regs_q[r*REG_W +: REG_W];
            end
        end
    end

    // Response stage: one pulse per accepted command, data only for reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_data  <= (op == VOP_READ) ? rd_word : '0;
        end
    end

    // Trigger lane select: a write to mailbox 0 on the lane holding the trigger.
    assign trig_wr = (op == VOP_WRITE) && (reg_sel == '0)
                     && (lane_sel == LANE_W'(TRIG_LANE));

    svr_toggle_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (trig_wr),
        .new_bit(cmd_data[TRIG_POS]),
        .old_bit(regs_q[TRIG_BIT]),
        .ack    (irq_ack),
        .irq    (irq)
    );

    // Consumer view of the format fields of mailbox 0.
    assign fmt_code  = regs_q[FMT_W-1:0];
    assign fmt_valid = regs_q[VALID_BIT];

endmodule

// File: rtl/svr_mailbox_pair_chk.sv
// Module: svr_mailbox_pair_chk
// Assertion checker bound to svr_mailbox_pair. Watches its ports only.
module svr_mailbox_pair_chk
    import svr_pkg::*;
#(
    parameter int                NUM_REGS  = 2,
    parameter int                REG_W     = 32,
    parameter logic [NODE_W-1:0] NODE_ID   = 8'h01,
    parameter logic [VERB_W-1:0] VERB_BASE = 12'hFA6,
    parameter int                TRIG_BIT  = 31,
    parameter int                VALID_BIT = 30
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_valid,
    input logic [NODE_W-1:0]         cmd_node,
    input logic [VERB_W-1:0]         cmd_verb,
    input logic [PAY_W-1:0]          cmd_data,
    input logic                      irq_ack,
    input logic                      rsp_valid,
    input logic [REG_W-1:0]          rsp_data,
    input logic [NUM_REGS*REG_W-1:0] regs_q,
    input logic                      irq,
    input logic                      fmt_valid
);

    localparam int BYTES = REG_W / 8;
    localparam int SLOT  = BYTES + 1;
    localparam logic [VERB_W-1:0] TOP_VERB  = VERB_W'(int'(VERB_BASE) + TRIG_BIT / 8 + 1);
    localparam logic [VERB_W-1:0] RD1_VERB  = VERB_W'(int'(VERB_BASE) + SLOT);

    logic hit;
    logic top_wr;
    logic flip;

    assign hit    = cmd_valid && (cmd_node == NODE_ID);
    assign top_wr = hit && (cmd_verb == TOP_VERB);
    assign flip   = top_wr && (cmd_data[TRIG_BIT % 8] != regs_q[TRIG_BIT]);

    // R1: foreign node commands leave no trace
    assert_foreign_node_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_node != NODE_ID) |=> (!rsp_valid && $stable(regs_q)));

    // R7: response pulse only after an accepted command
    assert_rsp_has_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(hit));

    // R7: every accepted command is answered
    assert_accept_answered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> rsp_valid);

    // R8: anything but a read verb answers zero
    assert_nonread_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && cmd_verb != VERB_BASE && cmd_verb != RD1_VERB) |=> (rsp_data == '0));

    // R5: trigger change raises the interrupt
    assert_flip_raises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        flip |=> irq);

    // R5: no interrupt without a trigger change
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !flip) |=> !irq);

    // R6: pending interrupt holds until acknowledged
    assert_irq_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_ack) |=> irq);

    // R6: acknowledge without a concurrent change clears
    assert_ack_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !flip) |=> !irq);

    // R10: valid flag follows payload bit 6 of the top-byte write
    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        top_wr |=> (fmt_valid == $past(cmd_data[VALID_BIT % 8])));

endmodule

bind svr_mailbox_pair svr_mailbox_pair_chk #(
    .NUM_REGS (NUM_REGS),
    .REG_W    (REG_W),
    .NODE_ID  (NODE_ID),
    .VERB_BASE(VERB_BASE),
    .TRIG_BIT (TRIG_BIT),
    .VALID_BIT(VALID_BIT)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_valid(cmd_valid),
    .cmd_node (cmd_node),
    .cmd_verb (cmd_verb),
    .cmd_data (cmd_data),
    .irq_ack  (irq_ack),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_data),
    .regs_q   (regs_q),
    .irq      (irq),
    .fmt_valid(fmt_valid)
);

// File: tb/svr_mailbox_pair_tb.sv
// Scoreboard bench: the driver task predicts each response into a queue,
// the monitor pops and compares whenever a response pulse appears.
module svr_mailbox_pair_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [7:0]  cmd_node = 8'h00;
    logic [11:0] cmd_verb = 12'h000;
    logic [7:0]  cmd_data = 8'h00;
    logic        irq_ack = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_data;
    logic [63:0] regs_q;
    logic        irq;
    logic [15:0] fmt_code;
    logic        fmt_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] m_reg[2];
    logic        m_irq;

    always #2.5 clk = ~clk;

    svr_mailbox_pair u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_node (cmd_node),
        .cmd_verb (cmd_verb),
        .cmd_data (cmd_data),
        .irq_ack  (irq_ack),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .regs_q   (regs_q),
        .irq      (irq),
        .fmt_code (fmt_code),
        .fmt_valid(fmt_valid)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        chk({req, " reg0"}, regs_q[31:0], m_reg[0]);
        chk({req, " reg1"}, regs_q[63:32], m_reg[1]);
        chk({req, " irq"}, {31'd0, irq}, {31'd0, m_irq});
        chk({req, " fmt_code"}, {16'd0, fmt_code}, {16'd0, m_reg[0][15:0]});
        chk({req, " fmt_valid"}, {31'd0, fmt_valid}, {31'd0, m_reg[0][30]});
    endtask

    // Driver: present one command, predict response and state.
    task automatic send(input logic [7:0] node, input logic [11:0] verb,
                        input logic [7:0] data, input logic ack, input string req);
        logic flip = 1'b0;
        int   ri = -1;
        int   ln = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_node = node; cmd_verb = verb; cmd_data = data;
        irq_ack = ack;
        if (node == 8'h01) begin
            case (verb)
                12'hFA6: begin exp_q.push_back(m_reg[0]); tag_q.push_back(req); end
                12'hFAB: begin exp_q.push_back(m_reg[1]); tag_q.push_back(req); end
                12'hFA7, 12'hFA8, 12'hFA9, 12'hFAA: begin ri = 0; ln = int'(verb - 12'hFA7); end
                12'hFAC, 12'hFAD, 12'hFAE, 12'hFAF: begin ri = 1; ln = int'(verb - 12'hFAC); end
                default: begin exp_q.push_back(32'd0); tag_q.push_back(req); end
            endcase
            if (ri >= 0) begin
                exp_q.push_back(32'd0); tag_q.push_back(req);
                if (ri == 0 && ln == 3 && data[7] != m_reg[0][31]) flip = 1'b1;
                m_reg[ri][ln*8 +: 8] = data;
            end
        end
        if (flip) m_irq = 1'b1;
        else if (ack) m_irq = 1'b0;
        @(negedge clk);
        cmd_valid = 1'b0; irq_ack = 1'b0;
    endtask

    task automatic ack_only();
        @(negedge clk);
        irq_ack = 1'b1;
        m_irq = 1'b0;
        @(negedge clk);
        irq_ack = 1'b0;
    endtask

    // Monitor: compare each response pulse with the oldest prediction.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                chk("R7 unexpected response", 32'd1, 32'd0);
            end else begin
                chk(tag_q.pop_front(), rsp_data, exp_q.pop_front());
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R7 watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        m_reg[0] = '0; m_reg[1] = '0; m_irq = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        check_state("R9 reset");
        chk("R9 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);

        send(8'h01, 12'hFA6, 8'h00, 1'b0, "R2 read reg0 after reset");
        send(8'h01, 12'hFA7, 8'h34, 1'b0, "R7 write rsp zero");
        send(8'h01, 12'hFA8, 8'h12, 1'b0, "R3 byte1");
        send(8'h01, 12'hFA9, 8'hAB, 1'b0, "R3 byte2");
        check_state("R10 format after low bytes");
        send(8'h01, 12'hFAA, 8'hC0, 1'b0, "R5 trigger rise");
        check_state("R5 rise raises irq");
        send(8'h01, 12'hFA6, 8'h00, 1'b0, "R2 read reg0 full");
        ack_only();
        check_state("R6 ack clears");
        send(8'h01, 12'hFAA, 8'hC5, 1'b0, "R5 unchanged trigger");
        check_state("R5 no irq when unchanged, R10 bits 29:24 stored");
        send(8'h01, 12'hFAA, 8'h45, 1'b0, "R5 trigger fall");
        check_state("R5 fall raises irq");
        send(8'h01, 12'hFAA, 8'hC5, 1'b1, "R6 ack with toggle");
        check_state("R6 toggle beats ack");
        ack_only();
        check_state("R6 ack alone");
        send(8'h02, 12'hFAA, 8'h00, 1'b0, "R1 foreign node");
        send(8'h00, 12'hFA7, 8'hFF, 1'b0, "R1 foreign node");
        check_state("R1 foreign node no effect");
        send(8'h01, 12'hFAC, 8'h11, 1'b0, "R4 byte0");
        send(8'h01, 12'hFAD, 8'h22, 1'b0, "R4 byte1");
        send(8'h01, 12'hFAE, 8'h33, 1'b0, "R4 byte2");
        send(8'h01, 12'hFAF, 8'hC4, 1'b0, "R4 byte3");
        check_state("R4 reg1 bytes, no irq");
        send(8'h01, 12'hFAB, 8'h00, 1'b0, "R2 read reg1");
        send(8'h01, 12'hFB0, 8'hEE, 1'b0, "R8 unknown verb above");
        send(8'h01, 12'hFA5, 8'hEE, 1'b0, "R8 unknown verb below");
        check_state("R8 unknown verbs no effect");
        send(8'h01, 12'hFAA, 8'h00, 1'b0, "R10 clear valid");
        check_state("R10 valid cleared, R5 irq on fall");
        send(8'h01, 12'hFA6, 8'h00, 1'b0, "R2 read reg0 final");
        repeat (3) @(negedge clk);
        chk("R7 all responses seen", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule